// File: doc/BRIEF.md
# BCD Timekeeping Register Bank

This block is a byte-wide bank of eight registers placed in the top eight locations of a memory address space. Offset 0 holds a control byte. Offsets 1 to 7 hold the time and calendar fields in packed BCD, using a 24-hour clock. A set of live counters advances on every 1 Hz strobe, with calendar rollover. Software does not see the live counters directly. It reads a visible copy of them through a simple synchronous-write, combinational-read port that has an address, a write enable, write data and read data.

Two control bits manage the visible copy. The read-halt bit freezes the copy so that software can read a consistent snapshot while the live counters keep running. The write bit also freezes the copy and lets software edit it. When software then clears the write bit, the edited fields are loaded into the live counters in that same clock edge.

Three fields live outside the frozen copy and take effect as soon as they are written:
- A stop flag, held in the seconds byte, gates counting.
- A frequency-test flag, held in the day byte, replaces seconds bit 0 on reads with a 512 Hz input square wave.
- Six calibration bits in the control byte are stored and exported to external calibration logic.

Top module: `bcd_clock_bank`

## Requirements
- R1: After reset, the bank reads as follows: control 00, seconds 80 (stop set, count zero), minutes 00, hours 00, day 01, date 01, month 01, year 00. The calibration output is 0.
- R2: An address selects the bank only when all address bits above the low three are 1. Offset 0 is control. Offsets 1 to 7 are seconds, minutes, hours, day, date, month and year. Any other address reads 00, and a write to it changes nothing.
- R3: A 1 Hz strobe sampled at clock edge k, with the stop flag clear, advances the seconds count by one in BCD. The new value can be read after edge k+1.
- R4: The fields roll over from seconds 59, minutes 59, hours 23, day 7 (to 1), month 12 (to 1) and year 99 (to 00). Each rollover carries into the next field. A field already at or above its top value wraps on the next advance.
- R5: Date rolls over to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. For February it is 29 when the two-digit year is a multiple of 4, and 28 otherwise.
- R6: While control bit 6 (read halt) is 1, the visible fields hold the values they had when the bit was set, and the live count keeps running. After the bit is cleared, the next edge shows the current live count.
- R7: While control bit 7 (write) is 1, writes to offsets 1 to 7 update the visible fields. A control write that clears bit 7 loads all seven visible fields into the live counters at that edge. A strobe in the same cycle is overridden by the load.
- R8: With neither halt bit set, a write to a time field is dropped, because the visible copy is refreshed from the live count at every edge.
- R9: Seconds bit 7 is the stop flag. It is written at any time. While it is 1, strobes do not advance the count. After it is cleared, the next strobe advances the count.
- R10: Day bit 6 is the frequency-test flag. It is written at any time. While it is 1, seconds bit 0 reads the 512 Hz input.
- R11: The calibration output always equals control bits 5 to 0. Bit 5 is the sign and bits 4 to 0 are the magnitude.
- R12: Bits outside each field read 0. The field widths are: seconds 7, minutes 7, hours 6, day 3, date 6, month 5, year 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz_i | input | 1 | One-cycle strobe, once per second |
| sq512_i | input | 1 | 512 Hz test square wave |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| cal_o | output | 6 | Calibration sign and magnitude |

## Verification
Reads are combinational from the registers. A write or control change sampled at edge k is therefore visible at the read port after edge k. A strobe sampled at edge k reaches the live counters at edge k, but reaches the visible copy only at edge k+1. The bench drives every input just after a falling edge and samples the outputs at the following falling edge, so one stimulus step always spans exactly one rising edge. Its reference model advances once per rising edge with the same one-edge lag for the visible copy. Directed reads are placed after the extra edge that a strobe needs.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hrs;
    logic [6:0] mins;
    logic [6:0] secs;
  } tk_time_t;

  localparam tk_time_t TIME_RST = '{yr: 8'h00, mon: 5'h01, date: 6'h01,
                                    dow: 3'h1, hrs: 6'h00, mins: 7'h00,
                                    secs: 7'h00};

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_SEC  = 3'd1;
  localparam logic [2:0] OFF_MIN  = 3'd2;
  localparam logic [2:0] OFF_HR   = 3'd3;
  localparam logic [2:0] OFF_DOW  = 3'd4;
  localparam logic [2:0] OFF_DATE = 3'd5;
  localparam logic [2:0] OFF_MON  = 3'd6;
  localparam logic [2:0] OFF_YR   = 3'd7;

  // Returns {wrap, next}: wraps to base when v is at or above top.
  function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] base);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = v[7:4];
    lo = v[3:0];
    if (v >= top)           return {1'b1, base};
    else if (lo >= 4'd9)    return {1'b0, hi + 4'd1, 4'd0};
    else                    return {1'b0, hi, lo + 4'd1};
  endfunction

  function automatic logic leap_bcd(input logic [7:0] yr);
    logic [3:0] lo;
    lo = yr[3:0];
    if (!yr[4]) return (lo == 4'd0) || (lo == 4'd4) || (lo == 4'd8);
    else        return (lo == 4'd2) || (lo == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [4:0] mon,
                                            input logic [7:0] yr);
    case (mon)
      5'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_clock_ctrl.sv
module bcd_clock_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl_i,
  input  logic       wr_sec_i,
  input  logic       wr_dow_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o,
  output logic       stop_o,
  output logic       ft_o,
  output logic       halt_o,
  output logic       xfer_o
);
  localparam int BIT_WR   = 7;
  localparam int BIT_RD   = 6;
  localparam int BIT_STOP = 7;
  localparam int BIT_FT   = 6;

  logic [7:0] ctrl_q, ctrl_d;
  logic       stop_q, stop_d;
  logic       ft_q, ft_d;

  always_comb begin
    ctrl_d = ctrl_q;
    stop_d = stop_q;
    ft_d   = ft_q;
    if (wr_ctrl_i) ctrl_d = wdata_i;
    if (wr_sec_i)  stop_d = wdata_i[BIT_STOP];
    if (wr_dow_i)  ft_d   = wdata_i[BIT_FT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      stop_q <= 1'b1;
      ft_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      stop_q <= stop_d;
      ft_q   <= ft_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stop_o = stop_q;
  assign ft_o   = ft_q;
  assign halt_o = ctrl_q[BIT_WR] | ctrl_q[BIT_RD];
  assign xfer_o = wr_ctrl_i & ctrl_q[BIT_WR] & ~wdata_i[BIT_WR];
endmodule

// File: rtl/bcd_clock_live.sv
module bcd_clock_live
  import bcd_clock_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv_i,
  input  logic     load_i,
  input  tk_time_t load_val_i,
  output tk_time_t live_o
);
  tk_time_t live_q, live_d;
  logic [8:0] s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr;

  always_comb begin
    s_sec  = bcd_step({1'b0, live_q.secs}, 8'h59, 8'h00);
    s_min  = bcd_step({1'b0, live_q.mins}, 8'h59, 8'h00);
    s_hr   = bcd_step({2'b0, live_q.hrs},  8'h23, 8'h00);
    s_dow  = bcd_step({5'b0, live_q.dow},  8'h07, 8'h01);
    s_date = bcd_step({2'b0, live_q.date},
                      month_last(live_q.mon, live_q.yr), 8'h01);
    s_mon  = bcd_step({3'b0, live_q.mon},  8'h12, 8'h01);
    s_yr   = bcd_step(live_q.yr,           8'h99, 8'h00);

    live_d = live_q;
    if (load_i) begin
      live_d = load_val_i;
    end else if (adv_i) begin
      live_d.secs = s_sec[6:0];
      if (s_sec[8]) begin
        live_d.mins = s_min[6:0];
        if (s_min[8]) begin
          live_d.hrs = s_hr[5:0];
          if (s_hr[8]) begin
            live_d.dow  = s_dow[2:0];
            live_d.date = s_date[5:0];
            if (s_date[8]) begin
              live_d.mon = s_mon[4:0];
              if (s_mon[8]) live_d.yr = s_yr[7:0];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= TIME_RST;
    else        live_q <= live_d;
  end

  assign live_o = live_q;
endmodule

// File: rtl/bcd_clock_visible.sv
module bcd_clock_visible
  import bcd_clock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  tk_time_t   live_i,
  input  logic       wr_i,
  input  logic [2:0] off_i,
  input  logic [7:0] wdata_i,
  output tk_time_t   vis_o
);
  tk_time_t vis_q, vis_d;

  always_comb begin
    vis_d = vis_q;
    if (!halt_i) begin
      vis_d = live_i;
    end else if (wr_i) begin
      case (off_i)
        OFF_SEC:  vis_d.secs = wdata_i[6:0];
        OFF_MIN:  vis_d.mins = wdata_i[6:0];
        OFF_HR:   vis_d.hrs  = wdata_i[5:0];
        OFF_DOW:  vis_d.dow  = wdata_i[2:0];
        OFF_DATE: vis_d.date = wdata_i[5:0];
        OFF_MON:  vis_d.mon  = wdata_i[4:0];
        OFF_YR:   vis_d.yr   = wdata_i;
        default:  vis_d = vis_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vis_q <= TIME_RST;
    else        vis_q <= vis_d;
  end

  assign vis_o = vis_q;
endmodule

// File: rtl/bcd_clock_bank.sv
module bcd_clock_bank
  import bcd_clock_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz_i,
  input  logic              sq512_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [5:0]        cal_o
);
  localparam int OFF_W = 3;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic             hit;
  logic [OFF_W-1:0] off;
  logic             wr;
  logic [7:0]       ctrl_q;
  logic             stop_q, ft_q, halt, xfer;
  tk_time_t         live_q, vis_q;

  assign hit = (addr_i[ADDR_W-1:OFF_W] == {TAG_W{1'b1}});
  assign off = addr_i[OFF_W-1:0];
  assign wr  = hit & we_i;

  bcd_clock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr && off == OFF_CTRL),
    .wr_sec_i  (wr && off == OFF_SEC),
    .wr_dow_i  (wr && off == OFF_DOW),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl_q),
    .stop_o    (stop_q),
    .ft_o      (ft_q),
    .halt_o    (halt),
    .xfer_o    (xfer)
  );

  bcd_clock_live u_live (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (tick_1hz_i & ~stop_q),
    .load_i     (xfer),
    .load_val_i (vis_q),
    .live_o     (live_q)
  );

  bcd_clock_visible u_vis (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt_i  (halt),
    .live_i  (live_q),
    .wr_i    (wr),
    .off_i   (off),
    .wdata_i (wdata_i),
    .vis_o   (vis_q)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (hit) begin
      case (off)
        OFF_CTRL: rdata_o = ctrl_q;
        OFF_SEC:  rdata_o = {stop_q, vis_q.secs[6:1],
                             ft_q ? sq512_i : vis_q.secs[0]};
        OFF_MIN:  rdata_o = {1'b0, vis_q.mins};
        OFF_HR:   rdata_o = {2'b0, vis_q.hrs};
        OFF_DOW:  rdata_o = {1'b0, ft_q, 3'b000, vis_q.dow};
        OFF_DATE: rdata_o = {2'b0, vis_q.date};
        OFF_MON:  rdata_o = {3'b0, vis_q.mon};
        OFF_YR:   rdata_o = vis_q.yr;
        default:  rdata_o = 8'h00;
      endcase
    end
  end

  assign cal_o = ctrl_q[5:0];
endmodule

// File: rtl/bcd_clock_bank_chk.sv
module bcd_clock_bank_chk
  import bcd_clock_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_i,
  input logic [7:0]        ctrl_i,
  input logic              stop_i,
  input tk_time_t          live_i,
  input tk_time_t          vis_i
);
  logic in_bank, bank_wr, load_now;
  assign in_bank  = &addr_i[ADDR_W-1:3];
  assign bank_wr  = in_bank & we_i;
  assign load_now = bank_wr && addr_i[2:0] == 3'd0 && ctrl_i[7] && !wdata_i[7];

  p_out_of_bank_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_bank |-> rdata_i == 8'h00);

  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !stop_i && !load_now && live_i.secs[3:0] < 4'd9 && live_i.secs < 7'h59)
    |=> live_i.secs == $past(live_i.secs) + 7'd1);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_now) |=> $stable(live_i));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[6] && !bank_wr) |=> $stable(vis_i));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> live_i == $past(vis_i));

  p_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[7] && !ctrl_i[6]) |=> vis_i == $past(live_i));

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_now) |=> $stable(live_i));
endmodule

bind bcd_clock_bank bcd_clock_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_i  (tick_1hz_i),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_i (rdata_o),
  .ctrl_i  (ctrl_q),
  .stop_i  (stop_q),
  .live_i  (live_q),
  .vis_i   (vis_q)
);

// File: tb/bcd_clock_bank_tb_top.sv
module bcd_clock_bank_tb_top;
  localparam int ADDR_W = 13;
  localparam logic [12:0] BASE = 13'h1FF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sq = 1'b0;
  logic [1:0] sqcnt = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [5:0] cal;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  always @(posedge clk) begin
    sqcnt <= sqcnt + 2'd1;
    if (sqcnt == 2'd3) sq <= ~sq;
  end

  bcd_clock_bank #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz_i(tick), .sq512_i(sq),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .cal_o(cal)
  );

  // Behavioural reference: binary integers indexed by offset.
  int lv[1:7];
  int vv[1:7];
  int mctrl, mstop, mft;
  int fmask[1:7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  function automatic int b2i(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int i2b(int i); return ((i / 10) << 4) | (i % 10); endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lv = '{0, 0, 0, 1, 1, 1, 0};
      vv = lv;
      mctrl = 0; mstop = 1; mft = 0;
    end else begin
      int old[1:7];
      bit hitm, wrm, halt_old, xf, c;
      int offm;
      old = lv;
      hitm = (addr[12:3] == 10'h3FF);
      offm = int'(addr[2:0]);
      wrm = hitm && we;
      halt_old = (mctrl & 8'hC0) != 0;
      xf = wrm && offm == 0 && (mctrl & 8'h80) != 0 && wdata[7] == 1'b0;
      if (xf) lv = vv;
      else if (tick && mstop == 0) begin
        c = 1'b0;
        if (lv[1] >= 59) begin lv[1] = 0; c = 1; end else lv[1]++;
        if (c) begin c = 0; if (lv[2] >= 59) begin lv[2] = 0; c = 1; end else lv[2]++; end
        if (c) begin c = 0; if (lv[3] >= 23) begin lv[3] = 0; c = 1; end else lv[3]++; end
        if (c) begin
          c = 0;
          if (lv[4] >= 7) lv[4] = 1; else lv[4]++;
          if (lv[5] >= mlen(old[6], old[7])) begin lv[5] = 1; c = 1; end else lv[5]++;
        end
        if (c) begin c = 0; if (lv[6] >= 12) begin lv[6] = 1; c = 1; end else lv[6]++; end
        if (c) begin if (lv[7] >= 99) lv[7] = 0; else lv[7]++; end
      end
      if (!halt_old) vv = old;
      else if (wrm && offm != 0) vv[offm] = b2i(int'(wdata) & fmask[offm]);
      if (wrm && offm == 0) mctrl = int'(wdata);
      if (wrm && offm == 1) mstop = int'(wdata[7]);
      if (wrm && offm == 4) mft = int'(wdata[6]);
    end
  end

  function automatic int model_rd(logic [12:0] a);
    int o;
    if (a[12:3] != 10'h3FF) return 0;
    o = int'(a[2:0]);
    case (o)
      0: return mctrl;
      1: return (mstop << 7) | (i2b(vv[1]) & 8'h7E) | (mft != 0 ? int'(sq) : (i2b(vv[1]) & 1));
      4: return (mft << 6) | i2b(vv[4]);
      default: return i2b(vv[o]);
    endcase
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One rising edge per step; compare at the following falling edge.
  task automatic step(bit t, bit w, logic [12:0] a, logic [7:0] d);
    tick = t; we = w; addr = a; wdata = d;
    @(negedge clk);
    chk(int'(rdata), model_rd(addr), tag);
    chk(int'(cal), mctrl & 8'h3F, "R11");
  endtask

  task automatic wr(int o, logic [7:0] d); step(0, 1, BASE + 13'(o), d); endtask
  task automatic tk(); step(1, 0, BASE, 8'h00); endtask
  task automatic expect_rd(logic [12:0] a, int exp, string req);
    step(0, 0, a, 8'h00);
    chk(int'(rdata), exp, req);
  endtask

  task automatic set_time(int s, int mi, int h, int dw, int dt, int mo, int y);
    wr(0, 8'h80);
    wr(1, 8'(s)); wr(2, 8'(mi)); wr(3, 8'(h)); wr(4, 8'(dw));
    wr(5, 8'(dt)); wr(6, 8'(mo)); wr(7, 8'(y));
    wr(0, 8'h00);
    step(0, 0, BASE, 8'h00);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    tag = "R1";
    expect_rd(BASE + 0, 8'h00, "R1");
    expect_rd(BASE + 1, 8'h80, "R1");
    expect_rd(BASE + 2, 8'h00, "R1");
    expect_rd(BASE + 3, 8'h00, "R1");
    expect_rd(BASE + 4, 8'h01, "R1");
    expect_rd(BASE + 5, 8'h01, "R1");
    expect_rd(BASE + 6, 8'h01, "R1");
    expect_rd(BASE + 7, 8'h00, "R1");
    chk(int'(cal), 0, "R1");
    // R2 outside the bank
    tag = "R2";
    expect_rd(13'h0010, 8'h00, "R2");
    expect_rd(13'h1FF0, 8'h00, "R2");
    // R8 dropped write, R9 stop clear
    tag = "R8";
    wr(1, 8'h00);
    wr(2, 8'h45);
    expect_rd(BASE + 2, 8'h00, "R8");
    tag = "R3";
    for (int i = 0; i < 3; i++) begin tk(); step(0, 0, BASE + 1, 8'h00); end
    expect_rd(BASE + 1, 8'h03, "R3");
    // R7 transfer with coincident strobe
    tag = "R7";
    wr(0, 8'h80);
    wr(1, 8'h58); wr(2, 8'h59); wr(3, 8'h23); wr(4, 8'h07);
    wr(5, 8'h28); wr(6, 8'h02); wr(7, 8'h23);
    step(1, 1, BASE, 8'h00);
    expect_rd(BASE + 1, 8'h58, "R7");
    // R4/R5 non-leap February end
    tag = "R4";
    tk(); tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 1, 8'h00, "R4");
    expect_rd(BASE + 2, 8'h00, "R4");
    expect_rd(BASE + 3, 8'h00, "R4");
    expect_rd(BASE + 4, 8'h01, "R4");
    expect_rd(BASE + 5, 8'h01, "R5");
    expect_rd(BASE + 6, 8'h03, "R5");
    // R5 leap February
    tag = "R5";
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 5, 8'h29, "R5");
    expect_rd(BASE + 6, 8'h02, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 5, 8'h01, "R5");
    expect_rd(BASE + 6, 8'h03, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 5, 8'h01, "R5");
    expect_rd(BASE + 6, 8'h05, "R5");
    // R4 full rollover to year 00
    tag = "R4";
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 5, 8'h01, "R4");
    expect_rd(BASE + 6, 8'h01, "R4");
    expect_rd(BASE + 7, 8'h00, "R4");
    expect_rd(BASE + 4, 8'h06, "R4");
    // R6 read halt
    tag = "R6";
    set_time(8'h10, 8'h00, 8'h12, 8'h01, 8'h15, 8'h06, 8'h30);
    wr(0, 8'h40);
    for (int i = 0; i < 3; i++) begin tk(); step(0, 0, BASE + 1, 8'h00); end
    expect_rd(BASE + 1, 8'h10, "R6");
    wr(0, 8'h00);
    expect_rd(BASE + 1, 8'h13, "R6");
    // R9 stop
    tag = "R9";
    wr(1, 8'h80);
    for (int i = 0; i < 3; i++) begin tk(); step(0, 0, BASE + 1, 8'h00); end
    expect_rd(BASE + 1, 8'h93, "R9");
    wr(1, 8'h00);
    tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 1, 8'h14, "R9");
    // R10 frequency test
    tag = "R10";
    wr(4, 8'h41);
    for (int i = 0; i < 10; i++) begin
      step(0, 0, BASE + 1, 8'h00);
      chk(int'(rdata[0]), int'(sq), "R10");
    end
    expect_rd(BASE + 4, 8'h41, "R10");
    wr(4, 8'h00);
    expect_rd(BASE + 1, 8'h14, "R10");
    // R11 calibration
    tag = "R11";
    wr(0, 8'h25);
    chk(int'(cal), 8'h25, "R11");
    expect_rd(BASE + 0, 8'h25, "R11");
    wr(0, 8'h00);
    // R12 unused bits
    tag = "R12";
    wr(0, 8'h80);
    wr(3, 8'hE3);
    wr(6, 8'hF2);
    expect_rd(BASE + 3, 8'h23, "R12");
    expect_rd(BASE + 6, 8'h12, "R12");
    wr(0, 8'h00);
    // R2 write outside the bank has no effect
    tag = "R2";
    step(0, 1, 13'h0FF9, 8'h80);
    tk(); step(0, 0, BASE, 8'h00);
    expect_rd(BASE + 1, 8'h15, "R2");
    repeat (4) step(0, 0, BASE + 1, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule